// File: doc/BRIEF.md
# Sample Accumulator with Arithmetic Shifter

This block is a 32-bit accumulate-and-divide engine placed beside the result stream of a data converter. It takes signed 24-bit samples on a one-cycle valid strobe. Software reaches it through a byte-wide register port. The accumulator appears there as four byte registers, least significant byte at the lowest address. Three more registers hold the control word, the sample target and the sample count.

A two-bit mode field picks one of four behaviours. Mode 0 adds software-written 32-bit values to the running total. Mode 1 collects a programmed number of converter samples and then stops. Mode 2 divides the total by a power of two on software request. Mode 3 collects samples and applies the divide automatically when the last sample arrives. When an automatic run finishes, a completion flag is set and drives the interrupt output. Software clears it by reading the count register. A typical use is averaging: program a target of 2^k samples and a shift of k, start mode 3, wait for the interrupt, then read the four accumulator bytes.

Top module: `sample_accum_shifter`

## Requirements
- R1: After a synchronous reset the accumulator, the sample count and the completion flag are zero, and the mode is 0.
- R2: A read at address 0..3 returns accumulator byte 0..3 (byte 0 = bits 7:0). Address 4 returns the control word, address 5 the target, and address 6 the sample count. reg_rdata is valid on the cycle after the reg_rd strobe.
- R3: In mode 0, writes to addresses 0..2 stage the low three bytes. A write to address 3 adds the 32-bit value {byte3, staged bytes} to the accumulator, modulo 2^32.
- R4: A write to the control register (address 4: bits 1:0 mode, bits 6:2 shift amount) that selects mode 1 or 3 starts a run. It clears the accumulator and the sample count.
- R5: During a run, each valid sample is sign-extended from 24 to 32 bits and added to the accumulator, and the sample count increases by one.
- R6: A run completes on the sample that makes the count equal the target register (address 5). A target of 0 acts as 1. Completion ends the run and sets the completion flag, which drives done_irq.
- R7: In mode 3, the completing sample's sum is stored arithmetically shifted right by the shift amount.
- R8: In mode 2, a write to address 3 loads the accumulator with {byte3, staged bytes}. A control write that selects mode 2 replaces the accumulator with its arithmetic right shift by the new shift amount.
- R9: Reading address 6 clears the completion flag. If a run completes in the same cycle, the flag stays set.
- R10: Samples that arrive outside a run are ignored and leave the accumulator and count unchanged. This covers modes 0 and 2, after completion, and in the cycle of a control write.
- R11: In modes 1 and 3, writes to addresses 0..3 leave the accumulator unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Registered read data, valid one cycle after reg_rd |
| smp_valid | input | 1 | Converter sample strobe |
| smp_data | input | 24 | Signed converter sample |
| done_irq | output | 1 | Completion flag of an automatic run |

## Verification
The bench uses the default parameters: a 32-bit accumulator, 24-bit samples, an 8-bit count and a 5-bit shift field. With these, negative samples exercise the sign extension. Shift amounts up to 31 are reachable, so a negative total can be driven all the way to minus one. Targets are kept small, 0 to 10, so that many complete runs fit in a short simulation. Random operation sequences are mixed with directed cases: target zero, a sample in the same cycle as a control write, samples after completion, and a manual divide of a negative value.

// File: rtl/accsh_pkg.sv
package accsh_pkg;
  typedef enum logic [1:0] {
    M_MAN_SUM   = 2'd0,
    M_AUTO_SUM  = 2'd1,
    M_MAN_SHIFT = 2'd2,
    M_AUTO_SHFT = 2'd3
  } accsh_mode_e;

  localparam int ADDR_W = 3;
  localparam logic [ADDR_W-1:0] A_CTL  = 3'd4;
  localparam logic [ADDR_W-1:0] A_TGT  = 3'd5;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd6;
endpackage

// File: rtl/accsh_sext_add.sv
module accsh_sext_add #(
  parameter int ACC_W = 32,
  parameter int SMP_W = 24
) (
  input  logic [ACC_W-1:0] acc,
  input  logic [SMP_W-1:0] smp,
  output logic [ACC_W-1:0] sum
);
  logic [ACC_W-1:0] smp_ext;
  generate
    if (SMP_W < ACC_W) begin : g_ext
      assign smp_ext = {{(ACC_W-SMP_W){smp[SMP_W-1]}}, smp};
    end else begin : g_pass
      assign smp_ext = smp[ACC_W-1:0];
    end
  endgenerate
  assign sum = acc + smp_ext;
endmodule

// File: rtl/accsh_shifter.sv
module accsh_shifter #(
  parameter int ACC_W = 32,
  parameter int SH_W  = 5
) (
  input  logic [ACC_W-1:0] din,
  input  logic [SH_W-1:0]  amt,
  output logic [ACC_W-1:0] dout
);
  assign dout = $unsigned($signed(din) >>> amt);
endmodule

// File: rtl/accsh_seq.sv
module accsh_seq #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             ctl_wr,
  input  logic             ctl_auto,
  input  logic             smp_valid,
  input  logic [CNT_W-1:0] target,
  input  logic             clr_done,
  output logic             run_q,
  output logic             take,
  output logic             fin,
  output logic [CNT_W-1:0] cnt_q,
  output logic             done_q
);
  logic [CNT_W-1:0] cnt_nxt;
  assign cnt_nxt = cnt_q + 1'b1;
  assign take    = run_q && smp_valid && !ctl_wr;
  assign fin     = take && ((cnt_nxt == target) || (target == '0));

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q  <= 1'b0;
      cnt_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (ctl_wr) begin
        run_q <= ctl_auto;
        if (ctl_auto) cnt_q <= '0;
      end else if (take) begin
        cnt_q <= cnt_nxt;
        if (fin) run_q <= 1'b0;
      end
      if (fin) done_q <= 1'b1;
      else if (clr_done) done_q <= 1'b0;
    end
  end
endmodule

// File: rtl/sample_accum_shifter.sv
module sample_accum_shifter #(
  parameter int ACC_W = 32,
  parameter int SMP_W = 24,
  parameter int CNT_W = 8
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [2:0]  reg_addr,
  input  logic [7:0]  reg_wdata,
  output logic [7:0]  reg_rdata,
  input  logic        smp_valid,
  input  logic [23:0] smp_data,
  output logic        done_irq
);
  import accsh_pkg::*;

  localparam int NB   = ACC_W / 8;
  localparam int SH_W = $clog2(ACC_W);

  logic [ACC_W-1:0]   acc_q;
  logic [ACC_W-9:0]   hold_q;
  accsh_mode_e        mode_q;
  logic [SH_W-1:0]    sh_q;
  logic [CNT_W-1:0]   tgt_q;
  logic [7:0]         rdata_q;

  logic               ctl_wr, ctl_auto, top_wr;
  accsh_mode_e        new_mode;
  logic [SH_W-1:0]    new_sh;
  logic               run_q, take, fin, done_q;
  logic [CNT_W-1:0]   cnt_q;
  logic [ACC_W-1:0]   sum, sh_in, sh_out, wval;
  logic [SH_W-1:0]    sh_amt;

  assign ctl_wr   = reg_wr && (reg_addr == A_CTL);
  assign new_mode = accsh_mode_e'(reg_wdata[1:0]);
  assign new_sh   = reg_wdata[2 +: SH_W];
  assign ctl_auto = (new_mode == M_AUTO_SUM) || (new_mode == M_AUTO_SHFT);
  assign top_wr   = reg_wr && (reg_addr == 3'(NB-1));
  assign wval     = {reg_wdata, hold_q};
  assign sh_in    = ctl_wr ? acc_q : sum;
  assign sh_amt   = ctl_wr ? new_sh : sh_q;

  accsh_sext_add #(.ACC_W(ACC_W), .SMP_W(SMP_W)) u_add (
    .acc(acc_q), .smp(smp_data[SMP_W-1:0]), .sum(sum)
  );

  accsh_shifter #(.ACC_W(ACC_W), .SH_W(SH_W)) u_shf (
    .din(sh_in), .amt(sh_amt), .dout(sh_out)
  );

  accsh_seq #(.CNT_W(CNT_W)) u_seq (
    .clk(clk), .rst(rst), .ctl_wr(ctl_wr), .ctl_auto(ctl_auto),
    .smp_valid(smp_valid), .target(tgt_q),
    .clr_done(reg_rd && (reg_addr == A_STAT)),
    .run_q(run_q), .take(take), .fin(fin), .cnt_q(cnt_q), .done_q(done_q)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q  <= '0;
      hold_q <= '0;
      mode_q <= M_MAN_SUM;
      sh_q   <= '0;
      tgt_q  <= '0;
    end else begin
      if (reg_wr && reg_addr == A_TGT) tgt_q <= reg_wdata[CNT_W-1:0];
      for (int i = 0; i < NB-1; i++)
        if (reg_wr && reg_addr == 3'(i)) hold_q[8*i +: 8] <= reg_wdata;
      if (ctl_wr) begin
        mode_q <= new_mode;
        sh_q   <= new_sh;
        if (ctl_auto) acc_q <= '0;
        else if (new_mode == M_MAN_SHIFT) acc_q <= sh_out;
      end else if (take) begin
        acc_q <= (fin && mode_q == M_AUTO_SHFT) ? sh_out : sum;
      end else if (top_wr) begin
        if (mode_q == M_MAN_SUM) acc_q <= acc_q + wval;
        else if (mode_q == M_MAN_SHIFT) acc_q <= wval;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rdata_q <= '0;
    else if (reg_rd) begin
      if (reg_addr < 3'(NB)) rdata_q <= acc_q[8*reg_addr +: 8];
      else if (reg_addr == A_CTL) rdata_q <= 8'({sh_q, mode_q});
      else if (reg_addr == A_TGT) rdata_q <= 8'(tgt_q);
      else if (reg_addr == A_STAT) rdata_q <= 8'(cnt_q);
      else rdata_q <= '0;
    end
  end

  assign reg_rdata = rdata_q;
  assign done_irq  = done_q;
endmodule

// File: rtl/accsh_checker.sv
module accsh_checker #(
  parameter int ACC_W = 32,
  parameter int CNT_W = 8
) (
  input logic             clk,
  input logic             rst,
  input logic             reg_wr,
  input logic             reg_rd,
  input logic [2:0]       reg_addr,
  input logic             smp_valid,
  input logic             done_irq,
  input logic [ACC_W-1:0] acc_q,
  input logic [CNT_W-1:0] cnt_q,
  input logic             run_q,
  input logic             fin
);
  a_r1_reset_clear: assert property (@(posedge clk)
    rst |=> (acc_q == '0 && cnt_q == '0 && !done_irq));

  a_r5_count_step: assert property (@(posedge clk) disable iff (rst)
    (run_q && smp_valid && !reg_wr) |=> (cnt_q == CNT_W'($past(cnt_q) + 1'b1)));

  a_r6_done_from_fin: assert property (@(posedge clk) disable iff (rst)
    $rose(done_irq) |-> $past(fin));

  a_r9_read_clears: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && reg_addr == 3'd6 && !fin) |=> !done_irq);

  a_r10_idle_hold: assert property (@(posedge clk) disable iff (rst)
    (!run_q && !reg_wr) |=> $stable(acc_q));
endmodule

bind sample_accum_shifter accsh_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
  .smp_valid(smp_valid), .done_irq(done_irq), .acc_q(acc_q), .cnt_q(cnt_q),
  .run_q(run_q), .fin(fin)
);

// File: tb/sim_sample_accum_shifter.sv
module sim_sample_accum_shifter;
  localparam int CLK_P = 10;

  logic clk = 1'b0, rst = 1'b1;
  logic reg_wr = 0, reg_rd = 0, smp_valid = 0;
  logic [2:0] reg_addr = 0;
  logic [7:0] reg_wdata = 0, reg_rdata;
  logic [23:0] smp_data = 0;
  logic done_irq;

  int checks = 0, errors = 0;

  logic [31:0] m_acc, m_hold;
  logic [7:0]  m_cnt, m_tgt;
  logic [1:0]  m_mode;
  logic [4:0]  m_sh;
  logic        m_run, m_done;

  always #(CLK_P/2) clk = ~clk;

  sample_accum_shifter u0 (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_rd(reg_rd), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .smp_valid(smp_valid),
    .smp_data(smp_data), .done_irq(done_irq)
  );

  function automatic logic [31:0] sx(input logic [23:0] v);
    return {{8{v[23]}}, v};
  endfunction
  function automatic logic [31:0] asr(input logic [31:0] v, input logic [4:0] s);
    logic [31:0] r = v;
    for (int i = 0; i < s; i++) r = {r[31], r[31:1]};
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk); reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_wr = 0;
    if (a < 3) m_hold[8*a +: 8] = d;
    else if (a == 3) begin
      if (m_mode == 0) m_acc = m_acc + {d, m_hold[23:0]};
      else if (m_mode == 2) m_acc = {d, m_hold[23:0]};
    end else if (a == 4) begin
      m_mode = d[1:0]; m_sh = d[6:2];
      m_run = (m_mode == 1 || m_mode == 3);
      if (m_run) begin m_acc = 0; m_cnt = 0; end
      else if (m_mode == 2) m_acc = asr(m_acc, m_sh);
    end else if (a == 5) m_tgt = d;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] v);
    @(negedge clk); reg_rd = 1; reg_addr = a;
    @(negedge clk); reg_rd = 0; v = reg_rdata;
    if (a == 6) m_done = 0;
  endtask

  task automatic smp(input logic [23:0] s);
    @(negedge clk); smp_valid = 1; smp_data = s;
    @(negedge clk); smp_valid = 0;
    if (m_run) begin
      m_acc = m_acc + sx(s); m_cnt++;
      if (m_cnt == m_tgt || m_tgt == 0) begin
        m_run = 0; m_done = 1;
        if (m_mode == 3) m_acc = asr(m_acc, m_sh);
      end
    end
  endtask

  task automatic chk_acc(input string req);
    logic [7:0] b; logic [31:0] v;
    for (int i = 0; i < 4; i++) begin rd(3'(i), b); v[8*i +: 8] = b; end
    chk(req, v, m_acc);
    chk({req, " irq"}, {31'b0, done_irq}, {31'b0, m_done});
  endtask

  task automatic chk_cnt(input string req);
    logic [7:0] b;
    chk({req, " irq"}, {31'b0, done_irq}, {31'b0, m_done});
    rd(3'd6, b);
    chk(req, {24'b0, b}, {24'b0, m_cnt});
  endtask

  task automatic put32(input logic [31:0] v);
    for (int i = 0; i < 4; i++) wr(3'(i), v[8*i +: 8]);
  endtask

  initial begin
    #(CLK_P * 200000);
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [7:0] b;
    logic [31:0] r;
    r = $urandom(32'd1234);
    m_acc = 0; m_hold = 0; m_cnt = 0; m_tgt = 0; m_mode = 0; m_sh = 0;
    m_run = 0; m_done = 0;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1 reset state
    chk_acc("R1 acc");
    chk_cnt("R1 count");
    rd(3'd4, b); chk("R1 mode", {24'b0, b}, 32'h0);

    // R3 manual summation with wrap, R2 byte order
    put32(32'h8000_0001); put32(32'h8000_0003);
    chk_acc("R3 manual sum wrap");
    rd(3'd0, b); chk("R2 byte0", {24'b0, b}, 32'h04);
    smp(24'h000100); chk_acc("R10 sample in mode 0");

    // R8 manual load and divide of a negative value
    wr(4, 8'h02); put32(32'hFFFF_FF00);
    chk_acc("R8 load");
    wr(4, {1'b0, 5'd4, 2'd2}); chk_acc("R8 shift by 4");
    wr(4, {1'b0, 5'd31, 2'd2}); chk_acc("R8 shift by 31");
    smp(24'h000055); chk_acc("R10 sample in mode 2");

    // R4 R5 R6 mode 1 with eight samples including negatives
    wr(5, 8); wr(4, 8'h01); chk_acc("R4 start clears");
    chk_cnt("R4 count cleared");
    wr(0, 8'h11); wr(3, 8'h22); chk_acc("R11 byte write ignored");
    for (int i = 0; i < 8; i++) smp(24'(i * 24'h0F0F0F + 24'h800000));
    chk_acc("R5 R6 auto sum");
    chk_cnt("R6 count eight, R9 clear");
    chk("R9 irq cleared", {31'b0, done_irq}, 32'h0);
    smp(24'h123456); chk_acc("R10 after completion");

    // R7 mode 3 averaging
    wr(5, 4); wr(4, {1'b0, 5'd2, 2'd3});
    smp(24'hFFFFF0); smp(24'hFFFFF4); smp(24'h000008); smp(24'hFFFFFC);
    chk_acc("R7 auto shift");
    chk_cnt("R7 count");

    // R6 target zero acts as one
    wr(5, 0); wr(4, 8'h01); smp(24'h000777);
    chk_acc("R6 target zero"); chk_cnt("R6 target zero count");

    // R10 sample in the same cycle as a control write
    wr(5, 3);
    @(negedge clk); reg_wr = 1; reg_addr = 4; reg_wdata = 8'h01;
    smp_valid = 1; smp_data = 24'h00ABCD;
    @(negedge clk); reg_wr = 0; smp_valid = 0;
    m_mode = 1; m_sh = 0; m_run = 1; m_acc = 0; m_cnt = 0;
    chk_acc("R10 sample during control write"); chk_cnt("R10 count after ctl");

    // random mix
    for (int k = 0; k < 60; k++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: put32($urandom());
        1: begin wr(5, 8'($urandom_range(0, 10))); wr(4, {1'b0, 5'($urandom_range(0, 31)), 2'($urandom_range(0, 3))}); end
        2, 3: for (int j = 0; j < 4; j++) smp(24'($urandom()));
        4: wr(4, {1'b0, 5'($urandom_range(0, 31)), 2'd2});
        default: chk_cnt("R5 R9 random count");
      endcase
      chk_acc("R3 R5 R7 R8 random");
    end

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule